// File: doc/BRIEF.md
# Two-Entry TLB Address Translator

This block turns a 15-bit virtual address into a 14-bit physical address. The page size is 4096 bytes, so the low twelve bits carry across unchanged. The upper bits are translated by a two-entry, fully associative translation buffer. Behind the buffer sits an eight-entry page table held in registers. A requester presents an address and a read/write flag. On a buffer hit the physical address comes back in the same cycle. On a miss the block raises `busy` for one cycle, reads the page table, refills the buffer and then completes. If the page-table entry is not valid, it reports a page fault instead.

The buffer refills the least recently used of its two entries. Each access marks the page as referenced, and a write also marks it dirty. These bits are kept in step between the buffer and the page table. System code fills the page table through a load port, which also throws out any buffered copy of the page it rewrites. A status port reads back any page-table entry without a clock delay. This lets the code that chooses pages for replacement see the reference and dirty bits. That choice itself is outside this block.

Top module: `tlbTranslator`

## Requirements
- R1: After reset every page-table entry reads invalid with reference and dirty bits at 0, the buffer is empty and the LRU marker points at entry 0. The first access therefore misses and then faults.
- R2: For every completed translation, `respPaddr[11:0]` equals `reqVaddr[11:0]` and `respPaddr[13:12]` is the physical page number.
- R3: An access whose virtual page (`reqVaddr[14:12]`) is held in a valid buffer entry completes in the same cycle: `respValid`=1 and `busy`=0.
- R4: An access that misses the buffer while its page-table entry is valid raises `busy` for exactly one cycle. In the next cycle, while the requester holds the request, the block raises `respValid` with the page-table frame and loads the buffer, so a later access to that page hits.
- R5: A miss whose page-table entry is invalid raises `busy` for one cycle. In the next cycle it raises `pageFault` with `respValid`=0 and `respPaddr`=0, and it leaves the buffer contents and the LRU marker unchanged.
- R6: A refill with both entries valid overwrites the entry that was used least recently. A hit or a fill makes the entry it used the most recent one.
- R7: When at least one buffer entry is invalid, a refill goes to the lowest-numbered invalid entry, whatever the LRU marker says.
- R8: Every completed access sets the page's reference bit, and a write access also sets its dirty bit. A read leaves the dirty bit as it was. The status port shows valid, reference, dirty and frame of the page-table entry selected by `statusVpn` without a clock delay.
- R9: A `ptLoad` pulse outside a fill cycle writes the valid bit and frame of the entry at `ptLoadVpn`, clears its reference and dirty bits, and invalidates any buffer entry that holds that page. A request presented in the same cycle sees `busy`=1 and no response.
- R10: A `ptLoad` pulse during the fill cycle of a miss is ignored, and the page table keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request; held while `busy` is 1 |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqVaddr | input | 15 | Virtual address |
| busy | output | 1 | Stall: hold the request one more cycle |
| respValid | output | 1 | Translation completed this cycle |
| respPaddr | output | 14 | Physical address, 0 when no response |
| pageFault | output | 1 | Miss found an invalid page-table entry |
| ptLoad | input | 1 | Write one page-table entry |
| ptLoadVpn | input | 3 | Page-table index to write |
| ptLoadValid | input | 1 | Valid bit to write |
| ptLoadPpn | input | 2 | Physical frame to write |
| statusVpn | input | 3 | Page-table index to read back |
| statusValid | output | 1 | Valid bit of the selected entry |
| statusRef | output | 1 | Reference bit of the selected entry |
| statusDirty | output | 1 | Dirty bit of the selected entry |
| statusPpn | output | 2 | Frame of the selected entry |

## Verification
The bench builds the block with its default widths: a 3-bit virtual page, a 2-bit frame and a 12-bit offset. With these widths every page-table entry can be read back after reset, and every frame value turns up in a translation. With only two buffer entries and eight pages, short access sequences can force evictions. That brings the LRU choice, refill into an empty slot after an invalidation, and overlaps of the load port with a pending miss all within reach. Both read and write accesses are used, so the dirty-bit rules can be observed through the status port.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef struct packed {
    logic captureReq;
    logic hitUpd;
    logic fillUpd;
    logic faultSeen;
    logic ptWrite;
  } tlbStrobeT;

  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} tlbStateT;
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      ptLoad,
  input  logic      hit,
  input  logic      ptValidRd,
  output tlbStrobeT stb,
  output logic      busy,
  output logic      respValid,
  output logic      pageFault
);
  tlbStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    busy      = 1'b0;
    respValid = 1'b0;
    pageFault = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (ptLoad) begin
          stb.ptWrite = 1'b1;
          busy        = reqValid;
        end else if (reqValid) begin
          if (hit) begin
            stb.hitUpd = 1'b1;
            respValid  = 1'b1;
          end else begin
            stb.captureReq = 1'b1;
            busy           = 1'b1;
            nextState      = ST_FILL;
          end
        end
      end
      default: begin
        nextState = ST_IDLE;
        if (ptValidRd) begin
          stb.fillUpd = 1'b1;
          respValid   = 1'b1;
        end else begin
          stb.faultSeen = 1'b1;
          pageFault     = 1'b1;
        end
      end
    endcase
  end

  // R4
  missCompletes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ptLoad) |=> (!busy && (respValid || pageFault)));
  // R5
  faultNoResp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pageFault && (respValid || busy)));
  // R3
  respNotBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && busy));
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int VPN_W = 3,
  parameter int PPN_W = 2,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobeT              stb,
  input  logic                   reqWrite,
  input  logic [VPN_W+OFF_W-1:0] reqVaddr,
  input  logic [VPN_W-1:0]       ptLoadVpn,
  input  logic                   ptLoadValid,
  input  logic [PPN_W-1:0]       ptLoadPpn,
  input  logic [VPN_W-1:0]       statusVpn,
  output logic                   hit,
  output logic                   ptValidRd,
  output logic [PPN_W+OFF_W-1:0] respPaddr,
  output logic                   statusValid,
  output logic                   statusRef,
  output logic                   statusDirty,
  output logic [PPN_W-1:0]       statusPpn
);
  localparam int PAGES       = 1 << VPN_W;
  localparam int NUM_ENTRIES = 2;

  logic [VPN_W-1:0] reqVpn;
  logic [OFF_W-1:0] reqOff;
  assign reqVpn = reqVaddr[VPN_W+OFF_W-1:OFF_W];
  assign reqOff = reqVaddr[OFF_W-1:0];

  logic [NUM_ENTRIES-1:0] tlbValid, tlbRef, tlbDirty, match;
  logic [VPN_W-1:0]       tlbVpn [NUM_ENTRIES];
  logic [PPN_W-1:0]       tlbPpn [NUM_ENTRIES];
  logic                   lru, hitIdx, victim;

  logic [PAGES-1:0]       ptValid, ptRef, ptDirty;
  logic [PPN_W-1:0]       ptPpn [PAGES];

  logic [VPN_W-1:0]       latVpn;
  logic [OFF_W-1:0]       latOff;
  logic                   latWrite;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gMatch
    assign match[e] = tlbValid[e] && (tlbVpn[e] == reqVpn);

    // R8
    entryInStep_chk: assert property (@(posedge clk) disable iff (!rstN)
      tlbValid[e] |-> (tlbRef[e] && ptRef[tlbVpn[e]] && (tlbDirty[e] == ptDirty[tlbVpn[e]])));
    // R9
    loadEvicts_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.ptWrite |=> !(tlbValid[e] && (tlbVpn[e] == $past(ptLoadVpn))));
  end

  assign hit       = |match;
  assign hitIdx    = match[1];
  assign victim    = !tlbValid[0] ? 1'b0 : (!tlbValid[1] ? 1'b1 : lru);
  assign ptValidRd = ptValid[latVpn];

  always_comb begin
    if (stb.fillUpd)     respPaddr = {ptPpn[latVpn], latOff};
    else if (stb.hitUpd) respPaddr = {tlbPpn[hitIdx], reqOff};
    else                 respPaddr = '0;
  end

  assign statusValid = ptValid[statusVpn];
  assign statusRef   = ptRef[statusVpn];
  assign statusDirty = ptDirty[statusVpn];
  assign statusPpn   = ptPpn[statusVpn];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbValid <= '0;
      tlbRef   <= '0;
      tlbDirty <= '0;
      lru      <= 1'b0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        tlbVpn[e] <= '0;
        tlbPpn[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (stb.ptWrite && tlbValid[e] && (tlbVpn[e] == ptLoadVpn)) tlbValid[e] <= 1'b0;
      end
      if (stb.hitUpd) begin
        tlbRef[hitIdx] <= 1'b1;
        if (reqWrite) tlbDirty[hitIdx] <= 1'b1;
        lru <= ~hitIdx;
      end
      if (stb.fillUpd) begin
        tlbValid[victim] <= 1'b1;
        tlbRef[victim]   <= 1'b1;
        tlbDirty[victim] <= ptDirty[latVpn] | latWrite;
        tlbVpn[victim]   <= latVpn;
        tlbPpn[victim]   <= ptPpn[latVpn];
        lru              <= ~victim;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptValid <= '0;
      ptRef   <= '0;
      ptDirty <= '0;
      for (int p = 0; p < PAGES; p++) ptPpn[p] <= '0;
    end else begin
      if (stb.ptWrite) begin
        ptValid[ptLoadVpn] <= ptLoadValid;
        ptRef[ptLoadVpn]   <= 1'b0;
        ptDirty[ptLoadVpn] <= 1'b0;
        ptPpn[ptLoadVpn]   <= ptLoadPpn;
      end
      if (stb.hitUpd) begin
        ptRef[reqVpn] <= 1'b1;
        if (reqWrite) ptDirty[reqVpn] <= 1'b1;
      end
      if (stb.fillUpd) begin
        ptRef[latVpn] <= 1'b1;
        if (latWrite) ptDirty[latVpn] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latVpn   <= '0;
      latOff   <= '0;
      latWrite <= 1'b0;
    end else if (stb.captureReq) begin
      latVpn   <= reqVpn;
      latOff   <= reqOff;
      latWrite <= reqWrite;
    end
  end

  // R6
  matchOnehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(match));
  // R5
  faultKeepsBuffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.faultSeen |=> ($stable(tlbValid) && $stable(lru)));
  // R4
  fillLeavesEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillUpd |=> ($countones(tlbValid) >= 1));
endmodule

// File: rtl/tlbTranslator.sv
module tlbTranslator
  import tlbPkg::*;
#(
  parameter int VPN_W = 3,
  parameter int PPN_W = 2,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [VPN_W+OFF_W-1:0] reqVaddr,
  output logic                   busy,
  output logic                   respValid,
  output logic [PPN_W+OFF_W-1:0] respPaddr,
  output logic                   pageFault,
  input  logic                   ptLoad,
  input  logic [VPN_W-1:0]       ptLoadVpn,
  input  logic                   ptLoadValid,
  input  logic [PPN_W-1:0]       ptLoadPpn,
  input  logic [VPN_W-1:0]       statusVpn,
  output logic                   statusValid,
  output logic                   statusRef,
  output logic                   statusDirty,
  output logic [PPN_W-1:0]       statusPpn
);
  tlbStrobeT stb;
  logic      hit, ptValidRd;

  tlbCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ptLoad(ptLoad),
    .hit(hit), .ptValidRd(ptValidRd), .stb(stb), .busy(busy),
    .respValid(respValid), .pageFault(pageFault)
  );

  tlbDatapath #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqVaddr(reqVaddr),
    .ptLoadVpn(ptLoadVpn), .ptLoadValid(ptLoadValid), .ptLoadPpn(ptLoadPpn),
    .statusVpn(statusVpn), .hit(hit), .ptValidRd(ptValidRd), .respPaddr(respPaddr),
    .statusValid(statusValid), .statusRef(statusRef), .statusDirty(statusDirty),
    .statusPpn(statusPpn)
  );
endmodule

// File: tb/test_tlbTranslator.sv
module test_tlbTranslator;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 3;
  localparam int PPN_W = 2;
  localparam int OFF_W = 12;
  localparam int PAGES = 1 << VPN_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [VPN_W+OFF_W-1:0] reqVaddr = '0;
  logic busy, respValid, pageFault;
  logic [PPN_W+OFF_W-1:0] respPaddr;
  logic ptLoad = 1'b0, ptLoadValid = 1'b0;
  logic [VPN_W-1:0] ptLoadVpn = '0, statusVpn = '0;
  logic [PPN_W-1:0] ptLoadPpn = '0;
  logic statusValid, statusRef, statusDirty;
  logic [PPN_W-1:0] statusPpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbTranslator #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) i_tlbTranslator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqVaddr(reqVaddr),
    .busy(busy), .respValid(respValid), .respPaddr(respPaddr), .pageFault(pageFault),
    .ptLoad(ptLoad), .ptLoadVpn(ptLoadVpn), .ptLoadValid(ptLoadValid), .ptLoadPpn(ptLoadPpn),
    .statusVpn(statusVpn), .statusValid(statusValid), .statusRef(statusRef),
    .statusDirty(statusDirty), .statusPpn(statusPpn)
  );

  int checks = 0, failures = 0;

  // behavioural reference model
  bit mPtV[PAGES], mPtR[PAGES], mPtD[PAGES];
  int mPtP[PAGES];
  bit mTV[2];
  int mTVpn[2], mTP[2];
  int mLru;
  bit mPend, mLW;
  int mLVpn, mLOff;
  bit lastBusy;

  task automatic modelReset();
    for (int p = 0; p < PAGES; p++) begin mPtV[p] = 0; mPtR[p] = 0; mPtD[p] = 0; mPtP[p] = 0; end
    for (int e = 0; e < 2; e++) begin mTV[e] = 0; mTVpn[e] = 0; mTP[e] = 0; end
    mLru = 0; mPend = 0; mLW = 0; mLVpn = 0; mLOff = 0;
  endtask

  task automatic doCycle(input bit rq, input bit wr, input int va, input bit ld, input int lv,
                         input bit lval, input int lp, input int sv, input string tag);
    bit eBusy, eResp, eFault, sV, sR, sD;
    int ePa, sP, vpn, off, hitE, vic;
    @(negedge clk);
    reqValid = rq; reqWrite = wr; reqVaddr = va[VPN_W+OFF_W-1:0];
    ptLoad = ld; ptLoadVpn = lv[VPN_W-1:0]; ptLoadValid = lval; ptLoadPpn = lp[PPN_W-1:0];
    statusVpn = sv[VPN_W-1:0];
    #1;
    sV = mPtV[sv]; sR = mPtR[sv]; sD = mPtD[sv]; sP = mPtP[sv];
    eBusy = 0; eResp = 0; eFault = 0; ePa = 0;
    vpn = va >> OFF_W; off = va % (1 << OFF_W);
    if (mPend) begin
      mPend = 0;
      if (mPtV[mLVpn]) begin
        eResp = 1; ePa = (mPtP[mLVpn] << OFF_W) + mLOff;
        vic = !mTV[0] ? 0 : (!mTV[1] ? 1 : mLru);
        mTV[vic] = 1; mTVpn[vic] = mLVpn; mTP[vic] = mPtP[mLVpn]; mLru = 1 - vic;
        mPtR[mLVpn] = 1; if (mLW) mPtD[mLVpn] = 1;
      end else eFault = 1;
    end else if (ld) begin
      eBusy = rq;
      mPtV[lv] = lval; mPtR[lv] = 0; mPtD[lv] = 0; mPtP[lv] = lp;
      for (int e = 0; e < 2; e++) if (mTV[e] && mTVpn[e] == lv) mTV[e] = 0;
    end else if (rq) begin
      hitE = -1;
      for (int e = 0; e < 2; e++) if (mTV[e] && mTVpn[e] == vpn) hitE = e;
      if (hitE >= 0) begin
        eResp = 1; ePa = (mTP[hitE] << OFF_W) + off; mLru = 1 - hitE;
        mPtR[vpn] = 1; if (wr) mPtD[vpn] = 1;
      end else begin
        eBusy = 1; mPend = 1; mLVpn = vpn; mLOff = off; mLW = wr;
      end
    end
    lastBusy = eBusy;
    checks++;
    if (busy !== eBusy || respValid !== eResp || pageFault !== eFault || respPaddr !== ePa[PPN_W+OFF_W-1:0] ||
        statusValid !== sV || statusRef !== sR || statusDirty !== sD || statusPpn !== sP[PPN_W-1:0]) begin
      failures++;
      $display("FAIL %s: got busy=%0b resp=%0b fault=%0b pa=%h st=%0b%0b%0b/%0d expected busy=%0b resp=%0b fault=%0b pa=%h st=%0b%0b%0b/%0d",
               tag, busy, respValid, pageFault, respPaddr, statusValid, statusRef, statusDirty, statusPpn,
               eBusy, eResp, eFault, ePa, sV, sR, sD, sP);
    end
  endtask

  task automatic access(input int va, input bit wr, input string tag);
    doCycle(1, wr, va, 0, 0, 0, 0, va >> OFF_W, tag);
    if (lastBusy) doCycle(1, wr, va, 0, 0, 0, 0, va >> OFF_W, tag);
  endtask

  task automatic idle(input int sv, input string tag);
    doCycle(0, 0, 0, 0, 0, 0, 0, sv, tag);
  endtask

  task automatic loadPt(input int v, input bit val, input int p, input string tag);
    doCycle(0, 0, 0, 1, v, val, p, v, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0; ptLoad = 0;
    repeat (2) @(negedge clk);
    modelReset();
    rstN = 1;
  endtask

  task automatic fillTable();
    loadPt(1, 1, 3, "R9"); loadPt(4, 1, 1, "R9");
    loadPt(5, 1, 2, "R9"); loadPt(7, 1, 0, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; failures++;
    $display("FAIL watchdog: got running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    doReset();
    for (int p = 0; p < PAGES; p++) idle(p, "R1");
    access('h5F38, 0, "R1");      // empty table: miss then fault
    access('h5F38, 0, "R5");
    fillTable();
    access('h113F, 1, "R4");      // write miss, fill entry 0
    access('h1ABC, 0, "R3");      // hit
    idle(1, "R8");
    access('h4F0A, 0, "R4");      // fill entry 1
    idle(4, "R8");
    access('h1000, 0, "R6");      // entry 0 most recent
    access('h5000, 1, "R6");      // replaces page 4
    access('h1234, 0, "R6");
    access('h4000, 0, "R6");      // replaces page 5
    access('h6123, 0, "R5");      // invalid page
    access('h1FFF, 0, "R5");
    access('h4001, 1, "R5");
    idle(4, "R8");
    for (int k = 0; k < 6; k++) access('h1000 + k * 'h2AB, k % 2, "R2");
    access('h7FFF, 0, "R2");
    // lowest invalid slot
    doReset();
    fillTable();
    access('h1010, 0, "R7");
    access('h4020, 0, "R7");
    loadPt(4, 1, 2, "R9");        // evict entry 1, lru marker on entry 0
    idle(4, "R9");
    access('h4030, 0, "R9");
    access('h1040, 0, "R7");      // entry 0 kept
    access('h4050, 1, "R7");
    // load port and request together
    doCycle(1, 0, 'h1060, 1, 5, 1, 3, 5, "R9");
    access('h1060, 0, "R9");
    access('h5070, 0, "R9");
    // load during fill cycle
    doCycle(1, 0, 'h7080, 0, 0, 0, 0, 7, "R10");
    doCycle(1, 0, 'h7080, 1, 7, 0, 3, 7, "R10");
    idle(7, "R10");
    access('h7090, 0, "R10");
    idle(0, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule